// File: doc/BRIEF.md
# Multisample Pixel Color Codec

This block packs the color samples of one multisampled pixel into a compact encoded word, and it unpacks such a word back into the full sample set. A pixel carries either 4 or 8 samples of 32-bit color. In most pixels every sample comes from a single shader result, and along a triangle edge a pixel usually mixes two results. The encoder therefore stores only the distinct colors and, for the two-color case, a bitmask that says which sample takes which color. A pixel with three or more distinct colors is stored raw. A separate cleared state carries no color at all, so a surface clear costs no per-sample writes.

The encoder and the decoder are independent valid/ready streams. The encoder takes a sample vector with a sample-count select and a clear flag, and returns one encoded word. The decoder takes an encoded word and returns the rebuilt samples together with a cleared flag. The encoder is a two-stage pipeline and the decoder has one stage. Both accept one pixel per clock when the output side is ready.

Top module: `msaa_color_codec`

## Requirements
- R1: With the clear flag set, the encoded state is CLEARED (code 0), the length and mask are 0 and every payload word is 0, whatever the sample values are.
- R2: When all active samples are equal and clear is low, the state is ONE_COLOR (code 1), the length is 1, the mask is 0 and payload word 0 holds the common color.
- R3: When exactly two distinct colors occur among the active samples, the state is TWO_COLOR (code 2) and the length is 2. Payload word 0 is the color of sample 0 and payload word 1 is the other color. Mask bit i is set exactly when sample i holds the color in word 1, so bit 0 is always clear.
- R4: When more than two distinct colors occur, the state is RAW (code 3), the length equals the active sample count, and payload word i holds sample i. The encoder never picks a larger state than the samples need.
- R5: With the sample-count select low (4 samples), samples 4 to 7 have no effect on the output: mask bits 7..4 and payload words 4..7 are 0, and the length of a RAW pixel is 4.
- R6: Layout of the encoded word (271 bits): bits 1:0 state, bit 2 the 8-sample select, bits 6:3 payload length in 32-bit words, bits 14:7 sample mask (bit 7+i for sample i), and payload word j at bits 15+32j upward. Unused fields are 0.
- R7: The decoder rebuilds every active sample bit-exactly from any word the encoder produces. Inactive samples come out as 0. A CLEARED word raises the cleared output and gives all-zero samples. The 8-sample select is passed through.
- R8: After reset no output is valid and the encoder input is ready. With the output ready, a pixel accepted on one clock edge appears at the encoder output two edges later, and a burst of N pixels completes in N+1 cycles after the first is accepted.
- R9: While the encoder output is valid and not ready, the word holds steady and no pixel is lost or duplicated.
- R10: A word accepted by the decoder appears at its output one edge later, and while the decoder output is valid and not ready, its outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Encoder input pixel present |
| enc_in_ready | output | 1 | Encoder can accept a pixel |
| enc_in_clear | input | 1 | Encode the pixel as cleared |
| enc_in_eight | input | 1 | 1: 8 samples per pixel, 0: 4 samples |
| enc_in_samples | input | 256 | Sample i color at bits 32i+31:32i |
| enc_out_valid | output | 1 | Encoded word present |
| enc_out_ready | input | 1 | Consumer takes the encoded word |
| enc_out_word | output | 271 | Encoded pixel |
| dec_in_valid | input | 1 | Decoder input word present |
| dec_in_ready | output | 1 | Decoder can accept a word |
| dec_in_word | input | 271 | Encoded pixel to rebuild |
| dec_out_valid | output | 1 | Rebuilt pixel present |
| dec_out_ready | input | 1 | Consumer takes the rebuilt pixel |
| dec_out_eight | output | 1 | Sample-count select of the rebuilt pixel |
| dec_out_cleared | output | 1 | Rebuilt pixel is in the cleared state |
| dec_out_samples | output | 256 | Rebuilt samples, same packing as the input |

## Verification
The case that is hardest to reach from the ports is a two-color pixel where sample 0 holds the minority color and the second color differs from it in a single bit. Only this case shows whether the second color is chosen by position and whether the comparators look at all 32 bits. Random colors almost never produce it, so the stimulus builds it directly from a base color with one flipped bit. It also places a lone odd sample at the last active position, which is the one most likely to be dropped by an off-by-one in the sample range. These pixels then pass through stalls from random backpressure, and each encoded word is fed back into the decoder for a round trip.

// File: rtl/msaa_codec_pkg.sv
package msaa_codec_pkg;

    localparam int COLOR_W  = 32;
    localparam int NS_MAX   = 8;
    localparam int NS_SMALL = 4;
    localparam int LEN_W    = $clog2(NS_MAX + 1);
    localparam int IDX_W    = $clog2(NS_MAX);

    typedef logic [NS_MAX-1:0][COLOR_W-1:0] samp_vec_t;

    typedef enum logic [1:0] {
        ST_CLEARED = 2'd0,
        ST_ONE     = 2'd1,
        ST_TWO     = 2'd2,
        ST_RAW     = 2'd3
    } pix_state_t;

    // Packed from MSB to LSB: state lands in bits 1:0.
    typedef struct packed {
        samp_vec_t          payload;
        logic [NS_MAX-1:0]  mask;
        logic [LEN_W-1:0]   len;
        logic               eight;
        pix_state_t         state;
    } enc_word_t;

    localparam int WORD_W = $bits(enc_word_t);

    typedef struct packed {
        samp_vec_t          samp;
        logic [NS_MAX-1:0]  eq0;
        logic               eight;
        logic               clear;
    } stage_a_t;

    function automatic logic [NS_MAX-1:0] active_mask(input logic eight);
        logic [NS_MAX-1:0] m;
        for (int i = 0; i < NS_MAX; i++) begin
            m[i] = eight || (i < NS_SMALL);
        end
        return m;
    endfunction

    function automatic logic [IDX_W-1:0] first_set(input logic [NS_MAX-1:0] v);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = NS_MAX - 1; i >= 0; i--) begin
            if (v[i]) idx = IDX_W'(i);
        end
        return idx;
    endfunction

    function automatic logic [LEN_W-1:0] sample_count(input logic eight);
        return eight ? LEN_W'(NS_MAX) : LEN_W'(NS_SMALL);
    endfunction

endpackage

// File: rtl/msaa_enc_front.sv
module msaa_enc_front
    import msaa_codec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      in_valid,
    input  logic      in_clear,
    input  logic      in_eight,
    input  samp_vec_t in_samp,
    output logic      a_valid,
    output stage_a_t  a_data
);

    logic [NS_MAX-1:0] eq0_c;

    // Every sample against sample 0 in parallel.
    for (genvar g = 0; g < NS_MAX; g++) begin : g_cmp0
        assign eq0_c[g] = (in_samp[g] == in_samp[0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_valid <= 1'b0;
            a_data  <= '0;
        end else if (en) begin
            a_valid      <= in_valid;
            a_data.samp  <= in_samp;
            a_data.eq0   <= eq0_c;
            a_data.eight <= in_eight;
            a_data.clear <= in_clear;
        end
    end

endmodule

// File: rtl/msaa_enc_back.sv
module msaa_enc_back
    import msaa_codec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      a_valid,
    input  stage_a_t  a_data,
    output logic      out_valid,
    output enc_word_t out_word
);

    logic [NS_MAX-1:0] act;
    logic [NS_MAX-1:0] diff0;
    logic [NS_MAX-1:0] eq1;
    logic [NS_MAX-1:0] extra;
    logic [IDX_W-1:0]  idx1;
    logic [COLOR_W-1:0] col1;
    enc_word_t         nxt;

    assign act   = active_mask(a_data.eight);
    assign diff0 = act & ~a_data.eq0;
    assign idx1  = first_set(diff0);
    assign col1  = a_data.samp[idx1];

    // Second comparison bank against the first color unlike sample 0.
    for (genvar g = 0; g < NS_MAX; g++) begin : g_cmp1
        assign eq1[g] = (a_data.samp[g] == col1);
    end

    assign extra = act & ~a_data.eq0 & ~eq1;

    always_comb begin
        nxt       = '0;
        nxt.eight = a_data.eight;
        if (a_data.clear) begin
            nxt.state = ST_CLEARED;
        end else if (diff0 == '0) begin
            nxt.state      = ST_ONE;
            nxt.len        = LEN_W'(1);
            nxt.payload[0] = a_data.samp[0];
        end else if (extra == '0) begin
            nxt.state      = ST_TWO;
            nxt.len        = LEN_W'(2);
            nxt.mask       = diff0;
            nxt.payload[0] = a_data.samp[0];
            nxt.payload[1] = col1;
        end else begin
            nxt.state = ST_RAW;
            nxt.len   = sample_count(a_data.eight);
            for (int i = 0; i < NS_MAX; i++) begin
                nxt.payload[i] = act[i] ? a_data.samp[i] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (en) begin
            out_valid <= a_valid;
            out_word  <= nxt;
        end
    end

    a_r1_clear_empty: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_word.state == ST_CLEARED |->
            out_word.len == '0 && out_word.mask == '0 && out_word.payload == '0);

    a_r2_one_len: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_word.state == ST_ONE |->
            out_word.len == LEN_W'(1) && out_word.mask == '0);

    a_r3_two_form: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_word.state == ST_TWO |->
            !out_word.mask[0] && out_word.mask != '0 &&
            out_word.payload[0] != out_word.payload[1]);

    a_r4_raw_len: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_word.state == ST_RAW |->
            out_word.len == sample_count(out_word.eight));

    a_r5_short_mask: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_word.eight |->
            out_word.mask[NS_MAX-1:NS_SMALL] == '0);

endmodule

// File: rtl/msaa_decode.sv
module msaa_decode
    import msaa_codec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      in_valid,
    input  enc_word_t in_word,
    output logic      out_valid,
    output logic      out_eight,
    output logic      out_cleared,
    output samp_vec_t out_samp
);

    logic [NS_MAX-1:0] act;
    samp_vec_t         rebuilt;

    assign act = active_mask(in_word.eight);

    for (genvar g = 0; g < NS_MAX; g++) begin : g_rebuild
        always_comb begin
            unique case (in_word.state)
                ST_CLEARED: rebuilt[g] = '0;
                ST_ONE:     rebuilt[g] = in_word.payload[0];
                ST_TWO:     rebuilt[g] = in_word.mask[g] ? in_word.payload[1]
                                                         : in_word.payload[0];
                default:    rebuilt[g] = in_word.payload[g];
            endcase
            if (!act[g]) rebuilt[g] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_eight   <= 1'b0;
            out_cleared <= 1'b0;
            out_samp    <= '0;
        end else if (en) begin
            out_valid   <= in_valid;
            out_eight   <= in_word.eight;
            out_cleared <= (in_word.state == ST_CLEARED);
            out_samp    <= rebuilt;
        end
    end

    a_r7_cleared_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_cleared |-> out_samp == '0);

    a_r7_short_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_eight |-> out_samp[NS_MAX-1:NS_SMALL] == '0);

endmodule

// File: rtl/msaa_color_codec.sv
module msaa_color_codec
    import msaa_codec_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enc_in_valid,
    output logic                      enc_in_ready,
    input  logic                      enc_in_clear,
    input  logic                      enc_in_eight,
    input  logic [NS_MAX*COLOR_W-1:0] enc_in_samples,
    output logic                      enc_out_valid,
    input  logic                      enc_out_ready,
    output logic [WORD_W-1:0]         enc_out_word,
    input  logic                      dec_in_valid,
    output logic                      dec_in_ready,
    input  logic [WORD_W-1:0]         dec_in_word,
    output logic                      dec_out_valid,
    input  logic                      dec_out_ready,
    output logic                      dec_out_eight,
    output logic                      dec_out_cleared,
    output logic [NS_MAX*COLOR_W-1:0] dec_out_samples
);

    logic      en_enc;
    logic      en_dec;
    logic      a_valid;
    stage_a_t  a_data;
    enc_word_t enc_word;
    samp_vec_t dec_samp;

    // One enable moves the whole encoder pipe; a stalled output freezes both stages.
    assign en_enc       = !enc_out_valid || enc_out_ready;
    assign enc_in_ready = en_enc;
    assign en_dec       = !dec_out_valid || dec_out_ready;
    assign dec_in_ready = en_dec;

    msaa_enc_front u_front (
        .clk      (clk),
        .rst      (rst),
        .en       (en_enc),
        .in_valid (enc_in_valid),
        .in_clear (enc_in_clear),
        .in_eight (enc_in_eight),
        .in_samp  (samp_vec_t'(enc_in_samples)),
        .a_valid  (a_valid),
        .a_data   (a_data)
    );

    msaa_enc_back u_back (
        .clk       (clk),
        .rst       (rst),
        .en        (en_enc),
        .a_valid   (a_valid),
        .a_data    (a_data),
        .out_valid (enc_out_valid),
        .out_word  (enc_word)
    );

    assign enc_out_word = enc_word;

    msaa_decode u_decode (
        .clk         (clk),
        .rst         (rst),
        .en          (en_dec),
        .in_valid    (dec_in_valid),
        .in_word     (enc_word_t'(dec_in_word)),
        .out_valid   (dec_out_valid),
        .out_eight   (dec_out_eight),
        .out_cleared (dec_out_cleared),
        .out_samp    (dec_samp)
    );

    assign dec_out_samples = dec_samp;

    a_r9_enc_hold: assert property (@(posedge clk) disable iff (rst)
        enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_word));

    a_r10_dec_hold: assert property (@(posedge clk) disable iff (rst)
        dec_out_valid && !dec_out_ready |=>
            dec_out_valid && $stable(dec_out_samples) && $stable(dec_out_cleared));

endmodule

// File: tb/test_msaa_color_codec.sv
module test_msaa_color_codec;

    localparam int NPIX = 240;
    localparam int WW   = 271;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            enc_in_valid = 1'b0;
    logic            enc_in_ready;
    logic            enc_in_clear = 1'b0;
    logic            enc_in_eight = 1'b0;
    logic [255:0]    enc_in_samples = '0;
    logic            enc_out_valid;
    logic            enc_out_ready = 1'b0;
    logic [WW-1:0]   enc_out_word;
    logic            dec_in_valid = 1'b0;
    logic            dec_in_ready;
    logic [WW-1:0]   dec_in_word = '0;
    logic            dec_out_valid;
    logic            dec_out_ready = 1'b0;
    logic            dec_out_eight;
    logic            dec_out_cleared;
    logic [255:0]    dec_out_samples;

    logic [255:0]    pix_s   [NPIX];
    bit              pix_8   [NPIX];
    bit              pix_clr [NPIX];
    logic [WW-1:0]   got     [NPIX];

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    msaa_color_codec i_msaa_color_codec (
        .clk(clk), .rst(rst),
        .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready),
        .enc_in_clear(enc_in_clear), .enc_in_eight(enc_in_eight),
        .enc_in_samples(enc_in_samples),
        .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
        .enc_out_word(enc_out_word),
        .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready),
        .dec_in_word(dec_in_word),
        .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
        .dec_out_eight(dec_out_eight), .dec_out_cleared(dec_out_cleared),
        .dec_out_samples(dec_out_samples)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected encoding derived from R1..R6.
    function automatic logic [WW-1:0] model_enc(input logic [255:0] s, input bit eight, input bit clr);
        logic [WW-1:0] w;
        logic [31:0] c0, c1;
        bit have1, raw;
        int n;
        w = '0;
        w[2] = eight;
        if (clr) return w;
        n = eight ? 8 : 4;
        c0 = s[31:0];
        c1 = '0;
        have1 = 0;
        raw = 0;
        for (int i = 0; i < n; i++) begin
            if (s[32*i +: 32] != c0) begin
                if (!have1) begin c1 = s[32*i +: 32]; have1 = 1; end
                else if (s[32*i +: 32] != c1) raw = 1;
            end
        end
        if (!have1) begin
            w[1:0] = 2'd1; w[6:3] = 4'd1; w[15 +: 32] = c0;
        end else if (!raw) begin
            w[1:0] = 2'd2; w[6:3] = 4'd2; w[15 +: 32] = c0; w[47 +: 32] = c1;
            for (int i = 0; i < n; i++) w[7+i] = (s[32*i +: 32] != c0);
        end else begin
            w[1:0] = 2'd3; w[6:3] = 4'(n);
            for (int i = 0; i < n; i++) w[15+32*i +: 32] = s[32*i +: 32];
        end
        return w;
    endfunction

    function automatic string tag_for(input int k);
        logic [WW-1:0] w;
        w = model_enc(pix_s[k], pix_8[k], pix_clr[k]);
        if (pix_clr[k]) return "R1";
        if (!pix_8[k])  return "R5";
        case (w[1:0])
            2'd1:    return "R2";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic make_pixel(input int k, input int p);
        logic [31:0] a, b, cc, msk;
        int n;
        a = $urandom; b = $urandom;
        if (b == a) b = ~a;
        cc = a ^ b ^ 32'h0000_0005;
        msk = $urandom;
        pix_clr[k] = (p == 4);
        pix_8[k] = (p == 5) ? 1'b0 : ((k < 8) ? 1'b1 : 1'($urandom % 2));
        n = pix_8[k] ? 8 : 4;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            case (p)
                0: v = a;
                1: v = msk[i] ? b : a;
                2: v = $urandom;
                3: case ($urandom % 3) 0: v = a; 1: v = b; default: v = cc; endcase
                4: v = $urandom;
                5: v = (i < 4) ? (msk[i] ? b : a) : $urandom;
                6: v = (i == 0) ? (a ^ (32'd1 << ($urandom % 32))) : a;
                default: v = (i == n - 1) ? b : a;
            endcase
            pix_s[k][32*i +: 32] = v;
        end
    endtask

    task automatic run_enc(input int first, input int cnt, input bit stress);
        int wr = first, rd = first, cyc = 0, in0 = -1, out0 = -1, outl = -1;
        bit stall = 0;
        logic [WW-1:0] hold = '0;
        while (rd < first + cnt) begin
            @(negedge clk);
            enc_in_valid = (wr < first + cnt) && (!stress || ($urandom % 4 != 0));
            if (wr < first + cnt) begin
                enc_in_samples = pix_s[wr];
                enc_in_eight   = pix_8[wr];
                enc_in_clear   = pix_clr[wr];
            end
            enc_out_ready = !stress || ($urandom % 4 != 0);
            #1;
            if (stall) check(enc_out_valid && enc_out_word == hold, "R9", enc_out_word, hold);
            if (enc_out_valid && enc_out_ready) begin
                logic [WW-1:0] e;
                e = model_enc(pix_s[rd], pix_8[rd], pix_clr[rd]);
                check(enc_out_word == e, tag_for(rd), enc_out_word, e);
                check(enc_out_word[6:3] == e[6:3], "R6", WW'(enc_out_word[6:3]), WW'(e[6:3]));
                got[rd] = enc_out_word;
                if (out0 < 0) out0 = cyc;
                outl = cyc;
                rd++;
            end
            stall = enc_out_valid && !enc_out_ready;
            hold  = enc_out_word;
            if (enc_in_valid && enc_in_ready) begin
                if (in0 < 0) in0 = cyc;
                wr++;
            end
            cyc++;
        end
        enc_in_valid = 1'b0;
        if (!stress) begin
            check(out0 - in0 == 2, "R8", WW'(out0 - in0), WW'(2));
            check(outl - in0 == cnt + 1, "R8", WW'(outl - in0), WW'(cnt + 1));
        end
    endtask

    task automatic run_dec(input int first, input int cnt, input bit stress);
        int wr = first, rd = first, cyc = 0, in0 = -1, out0 = -1;
        bit stall = 0;
        logic [255:0] hold = '0;
        while (rd < first + cnt) begin
            @(negedge clk);
            dec_in_valid = (wr < first + cnt) && (!stress || ($urandom % 4 != 0));
            if (wr < first + cnt) dec_in_word = got[wr];
            dec_out_ready = !stress || ($urandom % 4 != 0);
            #1;
            if (stall) check(dec_out_valid && dec_out_samples == hold, "R10",
                             WW'(dec_out_samples), WW'(hold));
            if (dec_out_valid && dec_out_ready) begin
                logic [255:0] e;
                e = pix_clr[rd] ? '0 : pix_s[rd];
                if (!pix_8[rd]) e[255:128] = '0;
                check(dec_out_samples == e, "R7", WW'(dec_out_samples), WW'(e));
                check(dec_out_cleared == pix_clr[rd] && dec_out_eight == pix_8[rd], "R7",
                      WW'({dec_out_cleared, dec_out_eight}), WW'({pix_clr[rd], pix_8[rd]}));
                if (out0 < 0) out0 = cyc;
                rd++;
            end
            stall = dec_out_valid && !dec_out_ready;
            hold  = dec_out_samples;
            if (dec_in_valid && dec_in_ready) begin
                if (in0 < 0) in0 = cyc;
                wr++;
            end
            cyc++;
        end
        dec_in_valid = 1'b0;
        if (!stress) check(out0 - in0 == 1, "R10", WW'(out0 - in0), WW'(1));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NPIX; k++) make_pixel(k, (k < 8) ? k : int'($urandom % 8));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!enc_out_valid && !dec_out_valid && enc_in_ready && dec_in_ready, "R8",
              WW'({enc_out_valid, dec_out_valid, enc_in_ready, dec_in_ready}), WW'(4'b0011));
        run_enc(0, 8, 1'b0);
        run_enc(8, NPIX - 8, 1'b1);
        run_dec(0, 8, 1'b0);
        run_dec(8, NPIX - 8, 1'b1);
        done = 1;
        $display("%0d/%0d checks passed", checks - errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", checks - errors, checks);
            $finish;
        end
    end

endmodule